// File: doc/BRIEF.md
# Host-Target Mailbox Register Interface

This block gives a 32-bit CPU bus two 64-bit mailbox registers for talking to a host-side agent. The outbound mailbox (to-host) carries commands and the inbound mailbox (from-host) carries replies. The CPU builds a command with two word writes: the low word first, then the high word. The high word triggers execution. Each command carries a device number in bits 63:56, a command number in bits 55:48 and a 48-bit payload in bits 47:0.

Two devices are supported.
- Device 0, command 0, with payload bit 0 set, is an exit request. It raises `done` and reports the exit code, which is the payload shifted right by one; zero means pass.
- Device 1 is a console. Command 1 (put) sends the low payload byte out through a valid/ready byte port. Command 0 (get) parks the command until a byte arrives on the input port.

Replies keep bits 63:48 of the command. Their 48-bit low field is 0x100 OR'd with the character.

A four-state controller sequences each command:
- `ST_IDLE`: waits for an accepted high-word write (transition *launch*).
- `ST_EXEC`: decodes the command for one cycle. *finish* returns to `ST_IDLE` for get, unknown and unsupported commands. *emit* goes to `ST_PUT` for put. *stop* goes to `ST_HALT` for exit.
- `ST_PUT`: holds the character until it is taken, then *drain* returns to `ST_IDLE`.
- `ST_HALT`: final; the controller never leaves it.

Top module: `hostlink_mailbox`

## Requirements
- R1: The bus `bus_addr` is a byte offset into the region. Each mailbox has a low word at its base offset and a high word at base+4; the defaults are from-host at 0 and to-host at 8. Reads return the addressed word combinationally. A from-host low write loads bits 31:0 and zeroes bits 63:32.
- R2: A to-host low write is taken only while to-host is zero, and then arms the high write. While to-host is nonzero, the write is dropped and disarms the high write.
- R3: A to-host high write is ORed into bits 63:32 and launches the command only when armed and idle; otherwise it is ignored.
- R4: An exit (device 0, command 0, payload bit 0 = 1) drives `done` high forever, with `exit_code` = payload >> 1. To-host keeps its value.
- R5: A put (device 1, command 1) holds `tx_valid` with `tx_data` = payload[7:0] until `tx_ready`. To-host stays unchanged until then.
- R6: When the put byte is accepted, from-host becomes {cmd[63:48], 48'h100 | byte} and to-host becomes zero.
- R7: A get (device 1, command 0) clears to-host, leaves from-host unchanged and stores the command. A later `rx_valid` byte sets from-host to {stored[63:48], 48'h100 | byte}.
- R8: Any other command, including device 0 with payload bit 0 clear, sets from-host to {cmd[63:48], 48'h0} and clears to-host.
- R9: An access to any other offset, including a misaligned one, reads zero, changes no register and raises `bad_access` for exactly one cycle in the following cycle.
- R10: A from-host high write ORs its data into bits 63:32.
- R11: After reset, both mailboxes read zero and `tx_valid`, `done` and `bad_access` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Word write strobe |
| bus_rd | input | 1 | Word read strobe |
| bus_addr | input | AW | Byte offset inside the mailbox region |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| bad_access | output | 1 | One-cycle pulse after an access to an unmapped offset |
| tx_valid | output | 1 | Console byte available |
| tx_ready | input | 1 | Console byte taken |
| tx_data | output | 8 | Console byte out |
| rx_valid | input | 1 | Console byte arriving |
| rx_data | input | 8 | Console byte in |
| done | output | 1 | Exit request seen |
| exit_code | output | 47 | Exit code of the exit request |

## Verification
The bench targets the arming rule:
- A high write with no prior low write must do nothing; a design that ignores the arm flag would print a stray character.
- A low write while a put is pending must be dropped; a design that accepts it would corrupt the queued byte.
- After that drop, a high write must also be ignored; a design that keeps the arm set would relaunch a command.

It also covers the exact reply layout and where each reply comes from. A get must not reply at once. The later byte must carry the stored command's top bits, not the current to-host. An exit must leave to-host intact, so that later writes are dropped. Unmapped and misaligned offsets must pulse `bad_access` without disturbing from-host.

// File: rtl/hostlink_pkg.sv
package hostlink_pkg;
    typedef enum logic [1:0] {ST_IDLE, ST_EXEC, ST_PUT, ST_HALT} hl_state_e;
    typedef enum logic [1:0] {ACT_OTHER, ACT_EXIT, ACT_PUT, ACT_GET} hl_act_e;

    localparam int MBOX_W    = 64;
    localparam int WORD_W    = 32;
    localparam int DEV_LSB   = 56;
    localparam int CMD_LSB   = 48;
    localparam int PAYLOAD_W = 48;
    localparam int CODE_W    = PAYLOAD_W - 1;
    localparam logic [7:0] DEV_SYS = 8'd0;
    localparam logic [7:0] DEV_CON = 8'd1;
    localparam logic [7:0] CMD_GET = 8'd0;
    localparam logic [7:0] CMD_PUT = 8'd1;

    function automatic logic [MBOX_W-1:0] mk_reply(logic [MBOX_W-1:0] cmd, logic [7:0] ch);
        return {cmd[MBOX_W-1:CMD_LSB], {(PAYLOAD_W-9){1'b0}}, 1'b1, ch};
    endfunction
endpackage

// File: rtl/hl_addr_map.sv
module hl_addr_map #(
    parameter int AW        = 8,
    parameter int TO_BASE   = 8,
    parameter int FROM_BASE = 0
) (
    input  logic [AW-1:0] addr,
    output logic          hit_to_lo,
    output logic          hit_to_hi,
    output logic          hit_fr_lo,
    output logic          hit_fr_hi,
    output logic          hit_any
);
    localparam int REGION_LO = (TO_BASE < FROM_BASE) ? TO_BASE : FROM_BASE;
    localparam int N_WORDS   = 4;

    logic [N_WORDS-1:0] hits;

    for (genvar g = 0; g < N_WORDS; g++) begin : g_word
        localparam int BASE_OFF = ((g < 2) ? TO_BASE : FROM_BASE) - REGION_LO;
        localparam int WORD_OFF = BASE_OFF + 4 * (g % 2);
        assign hits[g] = (addr == AW'(WORD_OFF));
    end

    assign hit_to_lo = hits[0];
    assign hit_to_hi = hits[1];
    assign hit_fr_lo = hits[2];
    assign hit_fr_hi = hits[3];
    assign hit_any   = |hits;
endmodule

// File: rtl/hl_cmd_decode.sv
module hl_cmd_decode
    import hostlink_pkg::*;
(
    input  logic [MBOX_W-1:0] cmd,
    output hl_act_e           act,
    output logic [7:0]        ch,
    output logic [CODE_W-1:0] code
);
    logic [7:0]           dev;
    logic [7:0]           op;
    logic [PAYLOAD_W-1:0] payload;

    assign dev     = cmd[MBOX_W-1:DEV_LSB];
    assign op      = cmd[DEV_LSB-1:CMD_LSB];
    assign payload = cmd[PAYLOAD_W-1:0];
    assign ch      = payload[7:0];
    assign code    = payload[PAYLOAD_W-1:1];

    always_comb begin
        act = ACT_OTHER;
        if (dev == DEV_SYS && op == 8'd0 && payload[0])
            act = ACT_EXIT;
        else if (dev == DEV_CON && op == CMD_PUT)
            act = ACT_PUT;
        else if (dev == DEV_CON && op == CMD_GET)
            act = ACT_GET;
    end
endmodule

// File: rtl/hostlink_mailbox.sv
module hostlink_mailbox
    import hostlink_pkg::*;
#(
    parameter int AW        = 8,
    parameter int TO_BASE   = 8,
    parameter int FROM_BASE = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [AW-1:0]     bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              bad_access,
    output logic              tx_valid,
    input  logic              tx_ready,
    output logic [7:0]        tx_data,
    input  logic              rx_valid,
    input  logic [7:0]        rx_data,
    output logic              done,
    output logic [CODE_W-1:0] exit_code
);
    hl_state_e         state, nxt;
    logic [MBOX_W-1:0] to_q, fr_q, pend_q;
    logic              arm_q, bad_q;
    logic [CODE_W-1:0] code_q;
    logic              hit_to_lo, hit_to_hi, hit_fr_lo, hit_fr_hi, hit_any;
    hl_act_e           act;
    logic [7:0]        dec_ch;
    logic [CODE_W-1:0] dec_code;
    logic              launch;

    hl_addr_map #(.AW(AW), .TO_BASE(TO_BASE), .FROM_BASE(FROM_BASE)) u_map (
        .addr(bus_addr), .hit_to_lo(hit_to_lo), .hit_to_hi(hit_to_hi),
        .hit_fr_lo(hit_fr_lo), .hit_fr_hi(hit_fr_hi), .hit_any(hit_any)
    );

    hl_cmd_decode u_dec (.cmd(to_q), .act(act), .ch(dec_ch), .code(dec_code));

    assign launch = bus_wr && hit_to_hi && arm_q && (state == ST_IDLE);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: if (launch) nxt = ST_EXEC;
            ST_EXEC: begin
                unique case (act)
                    ACT_EXIT: nxt = ST_HALT;
                    ACT_PUT:  nxt = ST_PUT;
                    default:  nxt = ST_IDLE;
                endcase
            end
            ST_PUT:  if (tx_ready) nxt = ST_IDLE;
            ST_HALT: nxt = ST_HALT;
        endcase
    end

    // mailbox datapath; controller updates come last and take priority
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            to_q   <= '0;
            fr_q   <= '0;
            pend_q <= '0;
            arm_q  <= 1'b0;
            code_q <= '0;
            bad_q  <= 1'b0;
        end else begin
            bad_q <= (bus_wr || bus_rd) && !hit_any;
            if (bus_wr && hit_to_lo) begin
                if (to_q == '0) begin
                    to_q  <= {{WORD_W{1'b0}}, bus_wdata};
                    arm_q <= 1'b1;
                end else begin
                    arm_q <= 1'b0;
                end
            end
            if (launch) begin
                to_q[MBOX_W-1:WORD_W] <= to_q[MBOX_W-1:WORD_W] | bus_wdata;
                arm_q <= 1'b0;
            end
            if (bus_wr && hit_fr_lo)
                fr_q <= {{WORD_W{1'b0}}, bus_wdata};
            if (bus_wr && hit_fr_hi)
                fr_q[MBOX_W-1:WORD_W] <= fr_q[MBOX_W-1:WORD_W] | bus_wdata;
            if (rx_valid)
                fr_q <= mk_reply(pend_q, rx_data);
            unique case (state)
                ST_EXEC: begin
                    unique case (act)
                        ACT_EXIT: code_q <= dec_code;
                        ACT_GET: begin
                            pend_q <= to_q;
                            to_q   <= '0;
                        end
                        ACT_OTHER: begin
                            fr_q <= {to_q[MBOX_W-1:CMD_LSB], {PAYLOAD_W{1'b0}}};
                            to_q <= '0;
                        end
                        default: ;
                    endcase
                end
                ST_PUT: begin
                    if (tx_ready) begin
                        fr_q <= mk_reply(to_q, dec_ch);
                        to_q <= '0;
                    end
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        tx_valid   = (state == ST_PUT);
        tx_data    = dec_ch;
        done       = (state == ST_HALT);
        exit_code  = code_q;
        bad_access = bad_q;
        bus_rdata  = '0;
        if (hit_to_lo)      bus_rdata = to_q[WORD_W-1:0];
        else if (hit_to_hi) bus_rdata = to_q[MBOX_W-1:WORD_W];
        else if (hit_fr_lo) bus_rdata = fr_q[WORD_W-1:0];
        else if (hit_fr_hi) bus_rdata = fr_q[MBOX_W-1:WORD_W];
    end
endmodule

// File: rtl/hostlink_mailbox_chk.sv
module hostlink_mailbox_chk
    import hostlink_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic              bad_access,
    input logic              tx_valid,
    input logic              tx_ready,
    input logic [7:0]        tx_data,
    input logic              done,
    input logic [CODE_W-1:0] exit_code,
    input logic [MBOX_W-1:0] to_q
);
    p_tx_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid && !tx_ready |=> tx_valid && $stable(tx_data) && $stable(to_q));

    p_put_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid && tx_ready |=> to_q == '0 && !tx_valid);

    p_done_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> done && $stable(exit_code));

    p_exit_keeps_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> to_q != '0 && !tx_valid);

    p_bad_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        bad_access |-> $past(bus_wr || bus_rd));
endmodule

bind hostlink_mailbox hostlink_mailbox_chk u_chk (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bad_access(bad_access), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_data(tx_data), .done(done), .exit_code(exit_code), .to_q(to_q)
);

// File: tb/sim_hostlink_mailbox.sv
module sim_hostlink_mailbox;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bad_access, tx_valid, done;
    logic        tx_ready = 1'b0;
    logic [7:0]  tx_data;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_data = '0;
    logic [46:0] exit_code;

    int n_run = 0, n_fail = 0;
    bit finished = 0;

    localparam logic [7:0] A_FR = 8'd0, A_TO = 8'd8;

    hostlink_mailbox u0 (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bad_access(bad_access), .tx_valid(tx_valid), .tx_ready(tx_ready),
        .tx_data(tx_data), .rx_valid(rx_valid), .rx_data(rx_data),
        .done(done), .exit_code(exit_code)
    );

    always #10 clk = ~clk;

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk); @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(logic [7:0] a, output logic [31:0] d);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(posedge clk); @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic rd64(logic [7:0] a, output logic [63:0] d);
        logic [31:0] lo, hi;
        rd(a, lo); rd(a + 8'd4, hi);
        d = {hi, lo};
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [63:0] v;
        rd64(A_TO, v); chk("R11 to-host after reset", v, 0);
        rd64(A_FR, v); chk("R11 from-host after reset", v, 0);
        chk("R11 tx_valid/done/bad", {tx_valid, done, bad_access}, 0);
    endtask

    task automatic t_fromhost();
        logic [63:0] v;
        wr(A_FR, 32'hAAAA5555); wr(A_FR + 4, 32'h0F00); wr(A_FR + 4, 32'h00F0);
        rd64(A_FR, v); chk("R10 from-host high OR", v, 64'h00000FF0_AAAA5555);
        wr(A_FR, 32'h1);
        rd64(A_FR, v); chk("R1 from-host low write zeroes high", v, 64'h1);
        wr(A_FR, 32'h0);
    endtask

    task automatic t_invalid();
        logic [31:0] d;
        logic [63:0] v;
        wr(8'd16, 32'hDEAD);
        chk("R9 bad_access after bad write", bad_access, 1);
        idle(1);
        chk("R9 bad_access single cycle", bad_access, 0);
        rd(8'd20, d);
        chk("R9 bad read returns zero", d, 0);
        chk("R9 bad_access after bad read", bad_access, 1);
        wr(8'd2, 32'hBEEF);
        chk("R9 misaligned write flagged", bad_access, 1);
        rd64(A_FR, v); chk("R9 from-host untouched", v, 0);
    endtask

    task automatic t_unarmed();
        logic [63:0] v;
        wr(A_TO + 4, 32'h01010000);
        idle(3);
        rd64(A_TO, v); chk("R3 unarmed high write ignored", v, 0);
        chk("R3 no put from unarmed write", tx_valid, 0);
    endtask

    task automatic t_put();
        logic [63:0] v;
        tx_ready = 1'b0;
        wr(A_TO, 32'h00000041); wr(A_TO + 4, 32'h01010000);
        idle(3);
        chk("R5 tx_valid held", tx_valid, 1);
        chk("R5 tx_data", tx_data, 8'h41);
        wr(A_TO, 32'h99);
        rd64(A_TO, v); chk("R2 busy low write dropped", v, 64'h01010000_00000041);
        chk("R5 tx still pending", tx_valid, 1);
        tx_ready = 1'b1; idle(1); tx_ready = 1'b0;
        idle(1);
        chk("R6 tx_valid drops", tx_valid, 0);
        rd64(A_FR, v); chk("R6 put reply", v, 64'h01010000_00000141);
        rd64(A_TO, v); chk("R6 to-host cleared", v, 0);
        wr(A_TO + 4, 32'h01010000);
        idle(3);
        rd64(A_TO, v); chk("R2 dropped write disarmed high", v, 0);
        chk("R2 no relaunch", tx_valid, 0);
    endtask

    task automatic t_get();
        logic [63:0] v;
        wr(A_FR, 32'h0);
        wr(A_TO, 32'h0); wr(A_TO + 4, 32'h01000000);
        idle(3);
        rd64(A_TO, v); chk("R7 get clears to-host", v, 0);
        rd64(A_FR, v); chk("R7 get gives no reply", v, 0);
        rx_data = 8'h5A; rx_valid = 1'b1; idle(1); rx_valid = 1'b0;
        rd64(A_FR, v); chk("R7 received byte reply", v, 64'h01000000_0000015A);
    endtask

    task automatic t_other();
        logic [63:0] v;
        wr(A_TO, 32'h1234); wr(A_TO + 4, 32'h07030000);
        idle(3);
        rd64(A_TO, v); chk("R8 unknown clears to-host", v, 0);
        rd64(A_FR, v); chk("R8 unknown reply", v, 64'h07030000_00000000);
        wr(A_TO, 32'h10); wr(A_TO + 4, 32'h0);
        idle(3);
        rd64(A_FR, v); chk("R8 syscall form gets zero reply", v, 0);
        chk("R8 syscall form not exit", done, 0);
    endtask

    task automatic t_exit();
        logic [63:0] v;
        wr(A_TO, 32'h0000000B); wr(A_TO + 4, 32'h0);
        idle(3);
        chk("R4 done", done, 1);
        chk("R4 exit code", 64'(exit_code), 5);
        wr(A_TO, 32'h0);
        rd64(A_TO, v); chk("R4 to-host retained after exit", v, 64'hB);
        chk("R4 done stays", done, 1);
    endtask

    initial begin
        #(20 * 200000);
        if (!finished) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);
        t_reset();
        t_fromhost();
        t_invalid();
        t_unarmed();
        t_put();
        t_get();
        t_other();
        t_exit();
        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule